// File: doc/BRIEF.md
# Deblocking Edge Skip Judge

This block decides whether one four-line segment of a block edge should pass through the deblocking filter or be skipped. For each segment it takes a boundary strength, a threshold beta, a flag for luma or chroma, and three samples on each side of the edge from the first line (line 0) and the last line (line 3) of the segment. For luma segments it computes a curvature measure from those samples and compares it against beta. For chroma segments only the boundary strength matters. The caller supplies the co-located luma strength for chroma segments.

The result is registered. One cycle after a valid strobe, the block presents a filter-on flag and the raw activity sum. A controller can store that sum to decide memory traffic for later edges. Beta and boundary strength are computed elsewhere, and the strong or weak filter choice happens downstream.

Top module: `edge_skip_judge`

## Requirements
- R1: While reset is asserted (rst_n low), and in the cycle after it, out_valid, filt_on and act_sum are all 0.
- R2: out_valid is high in exactly the cycles that follow a cycle with in_valid high.
- R3: After a valid strobe, act_sum equals d0 + d3. Here d = |p2 - 2*p1 + p0| + |q2 - 2*q1 + q0| on line 0 and on line 3. Each packed side port carries sample 0 in bits [7:0], sample 1 in [15:8] and sample 2 in [23:16], where sample 0 is nearest the edge.
- R4: A luma segment (is_chroma = 0) with bs = 0 gives filt_on = 0, whatever the samples and beta are.
- R5: A luma segment with nonzero bs gives filt_on = 1 exactly when act_sum < beta. A sum equal to beta skips the segment.
- R6: A chroma segment (is_chroma = 1) gives filt_on = 1 exactly when bs = 2 (binary 10). The samples and beta have no effect on filt_on.
- R7: In a cycle after in_valid is low, filt_on and act_sum keep their previous values.
- R8: The activity sum does not wrap. Samples of 255, 0, 255 on every side give act_sum = 2040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Segment strobe |
| is_chroma | input | 1 | 1 = chroma segment, 0 = luma |
| bs | input | 2 | Boundary strength, 0 to 2 |
| beta | input | 8 | Activity threshold |
| l0_p | input | 24 | Line 0, p side samples 2,1,0 |
| l0_q | input | 24 | Line 0, q side samples 2,1,0 |
| l3_p | input | 24 | Line 3, p side samples 2,1,0 |
| l3_q | input | 24 | Line 3, q side samples 2,1,0 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| filt_on | output | 1 | 1 = filter the segment, 0 = skip |
| act_sum | output | 11 | d0 + d3 |

## Verification
The test starts with hand-picked cases:
- a sum exactly at beta and one just below it, which tell a strict comparison from an inclusive one;
- maximal-curvature samples, which reveal a truncated or wrapped sum;
- chroma segments at each strength with hostile samples, which show whether the difference leaks into the chroma rule.

A long pseudo-random run follows. Its samples cluster around a common level so that sums land on both sides of beta. It mixes idle cycles in to exercise the hold behaviour, and it mixes strength values and component types so that each decision path is visited many times.

// File: rtl/edge_skip_judge.sv
module edge_skip_judge #(
  parameter int PIX_W  = 8,
  parameter int BETA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 is_chroma,
  input  logic [1:0]           bs,
  input  logic [BETA_W-1:0]    beta,
  input  logic [3*PIX_W-1:0]   l0_p,
  input  logic [3*PIX_W-1:0]   l0_q,
  input  logic [3*PIX_W-1:0]   l3_p,
  input  logic [3*PIX_W-1:0]   l3_q,
  output logic                 out_valid,
  output logic                 filt_on,
  output logic [PIX_W+2:0]     act_sum
);
  localparam int SD_W  = PIX_W + 2;
  localparam int AB_W  = PIX_W + 1;
  localparam int SUM_W = PIX_W + 3;
  localparam int CMP_W = (SUM_W > BETA_W) ? SUM_W : BETA_W;

  logic [3*PIX_W-1:0] side [4];
  logic [AB_W-1:0]    mag  [4];

  assign side[0] = l0_p;
  assign side[1] = l0_q;
  assign side[2] = l3_p;
  assign side[3] = l3_q;

  for (genvar s = 0; s < 4; s++) begin : g_side
    logic signed [SD_W-1:0] curv;
    assign curv = $signed({2'b00, side[s][3*PIX_W-1:2*PIX_W]})
                - $signed({1'b0, side[s][2*PIX_W-1:PIX_W], 1'b0})
                + $signed({2'b00, side[s][PIX_W-1:0]});
    assign mag[s] = curv[SD_W-1] ? AB_W'(-curv) : AB_W'(curv);
  end

  logic [SUM_W-1:0] sum_n;
  logic             luma_on, chroma_on;

  assign sum_n     = SUM_W'(mag[0]) + SUM_W'(mag[1]) + SUM_W'(mag[2]) + SUM_W'(mag[3]);
  assign luma_on   = (bs != 2'd0) && (CMP_W'(sum_n) < CMP_W'(beta));
  assign chroma_on = (bs == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      filt_on   <= 1'b0;
      act_sum   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        filt_on <= is_chroma ? chroma_on : luma_on;
        act_sum <= sum_n;
      end
    end
  end
endmodule

// File: rtl/edge_skip_judge_chk.sv
module edge_skip_judge_chk #(
  parameter int PIX_W  = 8,
  parameter int BETA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              is_chroma,
  input logic [1:0]        bs,
  input logic [BETA_W-1:0] beta,
  input logic              out_valid,
  input logic              filt_on,
  input logic [PIX_W+2:0]  act_sum
);
  localparam int SUM_W = PIX_W + 3;
  localparam int CMP_W = (SUM_W > BETA_W) ? SUM_W : BETA_W;
  localparam int MAX_SUM = 4 * 2 * ((1 << PIX_W) - 1);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_luma_zero_bs: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_chroma && bs == 2'd0) |=> !filt_on);
  a_r5_luma_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_chroma && bs != 2'd0) |=>
      (filt_on == (CMP_W'(act_sum) < CMP_W'($past(beta)))));
  a_r6_chroma_strength: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_chroma) |=> (filt_on == ($past(bs) == 2'd2)));
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(filt_on) && $stable(act_sum)));
  a_r8_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(act_sum) <= MAX_SUM));
endmodule

bind edge_skip_judge edge_skip_judge_chk #(.PIX_W(PIX_W), .BETA_W(BETA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_chroma(is_chroma),
  .bs(bs), .beta(beta), .out_valid(out_valid), .filt_on(filt_on),
  .act_sum(act_sum)
);

// File: tb/sim_edge_skip_judge.sv
`timescale 1ns/1ps
module sim_edge_skip_judge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        is_chroma = 1'b0;
  logic [1:0]  bs = 2'd0;
  logic [7:0]  beta = 8'd0;
  logic [23:0] l0_p = '0, l0_q = '0, l3_p = '0, l3_q = '0;
  logic        out_valid, filt_on;
  logic [10:0] act_sum;

  int checks = 0, failures = 0;
  bit done = 0;

  int    e_valid = 0, e_filt = 0, e_sum = 0;
  string e_tag = "R1";

  always #10 clk = ~clk;

  edge_skip_judge u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_chroma(is_chroma),
    .bs(bs), .beta(beta), .l0_p(l0_p), .l0_q(l0_q), .l3_p(l3_p), .l3_q(l3_q),
    .out_valid(out_valid), .filt_on(filt_on), .act_sum(act_sum)
  );

  function automatic logic [23:0] pk(int s2, int s1, int s0);
    return {8'(s2), 8'(s1), 8'(s0)};
  endfunction

  function automatic int curv(logic [23:0] v);
    int c;
    c = int'(v[23:16]) - 2 * int'(v[15:8]) + int'(v[7:0]);
    return (c < 0) ? -c : c;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit v, bit ch, int b, int bt,
                      logic [23:0] a0, logic [23:0] b0,
                      logic [23:0] a3, logic [23:0] b3);
    int s;
    in_valid = v; is_chroma = ch; bs = 2'(b); beta = 8'(bt);
    l0_p = a0; l0_q = b0; l3_p = a3; l3_q = b3;
    @(posedge clk);
    e_valid = v;
    if (v) begin
      s = curv(a0) + curv(b0) + curv(a3) + curv(b3);
      e_sum = s;
      if (ch) begin
        e_filt = (b == 2) ? 1 : 0; e_tag = "R6";
      end else if (b == 0) begin
        e_filt = 0; e_tag = "R4";
      end else begin
        e_filt = (s < bt) ? 1 : 0; e_tag = "R5";
      end
    end else e_tag = "R7";
    @(negedge clk);
    chk("R2 out_valid", out_valid, e_valid);
    chk({e_tag, " filt_on"}, filt_on, e_filt);
    chk((e_tag == "R7") ? "R7 act_sum" : "R3 act_sum", act_sum, e_sum);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] z;
    z = pk(0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 filt_on", filt_on, 0);
    chk("R1 act_sum", act_sum, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after release", out_valid, 0);

    // R5 boundary: sum equals beta skips, one above filters
    step(1, 0, 1, 10, pk(0, 0, 10), z, z, z);
    step(1, 0, 2, 11, pk(0, 0, 10), z, z, z);
    step(1, 0, 1, 0, z, z, z, z);
    // R4 zero strength with flat samples and large beta
    step(1, 0, 0, 255, z, z, z, z);
    // R8 maximal curvature on every side
    step(1, 0, 1, 255, pk(255, 0, 255), pk(255, 0, 255), pk(255, 0, 255), pk(255, 0, 255));
    if (act_sum != 11'd2040) begin failures++; $display("FAIL R8 actual=%0d expected=2040", act_sum); end
    checks++;
    // R7 idle cycles hold results
    step(0, 1, 2, 0, pk(9, 9, 9), z, z, z);
    step(0, 0, 1, 255, z, z, z, z);
    // R6 chroma at each strength with hostile samples
    for (int b = 0; b < 4; b++)
      step(1, 1, b, (b == 1) ? 255 : 0, pk(255, 0, 255), pk(0, 200, 0), z, pk(3, 1, 7));
    // R3 mixed directions on line 3
    step(1, 0, 2, 200, pk(100, 120, 90), pk(60, 20, 10), pk(5, 90, 200), pk(30, 30, 31));

    for (int i = 0; i < 600; i++) begin
      int base, spread;
      logic [23:0] s [4];
      base = $urandom_range(0, 255);
      spread = (i % 3 == 0) ? 60 : 12;
      for (int k = 0; k < 4; k++) begin
        int t [3];
        for (int j = 0; j < 3; j++) begin
          t[j] = base + $urandom_range(0, spread) - spread / 2;
          if (t[j] < 0) t[j] = 0;
          if (t[j] > 255) t[j] = 255;
        end
        s[k] = pk(t[2], t[1], t[0]);
      end
      step(($urandom_range(0, 3) != 0), ($urandom_range(0, 2) == 0),
           $urandom_range(0, 2), $urandom_range(0, 120), s[0], s[1], s[2], s[3]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule